// File: doc/BRIEF.md
# Three-Channel DAC and ADC Lockstep Sequencer

This block runs one shared serial bus to a three-channel DAC and a single-channel ADC. Each pulse on `sampleTick` starts one sample period. The period writes the three DAC channel registers one after another. A single internal strobe then drives the DAC load line low and the ADC conversion-start line high, so all three DAC outputs change together and each such update lines up with exactly one conversion. The period ends by reading the ADC result over the same bus.

The three channel words are copied into shadow registers when the period starts. The inputs may therefore change while the frames are on the wire. The run-time timing inputs set four things: the serial clock half-period, the minimum chip-select high time between frames, the delay from the last DAC chip-select release to the load strobe, and the width and relative delay of the two strobe pulses. A tick that arrives while a period is still running is dropped, and it sets a sticky overrun flag.

Top module: `dacAdcSequencer`

## Requirements
- R1: While reset is held, both chip selects and `ldacN` are high, `sclk`, `convst`, `mosi`, `adcValid` and `overrun` are low.
- R2: A tick in idle captures the three channel inputs. The bus then carries three DAC frames of 24 bits, MSB first, for channels 0, 1 and 2 in that order. Each frame is an 8-bit command byte equal to `CMD_BASE` plus the channel number (0, 1 or 2), followed by the 16-bit channel word.
- R3: The bus uses clock polarity 0 and phase 1. `sclk` idles low, `mosi` changes only on a rising `sclk` edge, and bits are taken on the falling edge. Each half-period lasts `sclkHalf` clocks, so a frame holds its chip select low for 48·`sclkHalf`+1 clocks.
- R4: `csDacN` is low only during the DAC frames and `csAdcN` is low only during the read frame. The two are never low together. Between two DAC frames the DAC chip select stays high for exactly `csGap` clocks.
- R5: `ldacN` falls exactly `ldacGap` clocks after `csDacN` rises at the end of the third DAC frame. It stays low for `pulseLen` clocks, and both chip selects are high while it is low.
- R6: `convst` rises exactly `convDelay` clocks after `ldacN` falls and stays high for `pulseLen` clocks (`convDelay` = 0 makes the edges coincide).
- R7: One 24-clock read frame follows the strobe, with `mosi` held at 0. `adcData` then holds the first 18 bits received, and `adcValid` is high for one clock starting at the edge where `csAdcN` returns high.
- R8: A tick while a period is running sets `overrun`, which stays set until reset. That tick starts no extra frames or strobes.
- R9: Changing the channel inputs after the starting tick does not alter the frames of the running period.
- R10: Every period contains exactly three DAC frames, one strobe, one read frame and one `adcValid` pulse, and the read frame starts after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One-clock pulse that starts a sample period |
| ch0Data | input | 16 | Sample word for DAC channel 0 |
| ch1Data | input | 16 | Sample word for DAC channel 1 |
| ch2Data | input | 16 | Sample word for DAC channel 2 |
| sclkHalf | input | 8 | Serial clock half-period in clocks (at least 1) |
| csGap | input | 8 | Minimum chip-select high time between frames (at least 1) |
| ldacGap | input | 8 | Clocks from DAC chip-select release to load strobe (at least 1) |
| convDelay | input | 8 | Clocks from load strobe to conversion start |
| pulseLen | input | 8 | Width of both strobe pulses in clocks (at least 1) |
| miso | input | 1 | Serial data from the ADC |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the devices |
| csDacN | output | 1 | DAC chip select, active low |
| csAdcN | output | 1 | ADC chip select, active low |
| ldacN | output | 1 | DAC load strobe, active low |
| convst | output | 1 | ADC conversion start, active high |
| adcData | output | 18 | Captured ADC sample |
| adcValid | output | 1 | One-clock pulse marking a new `adcData` |
| overrun | output | 1 | Sticky flag for a tick that arrived while a period was running |

## Verification
The bench uses the default parameters: 16-bit channel words, 24-bit frames, an 18-bit capture and 8-bit timing counts. Between sample periods it changes the run-time timing inputs, with half-periods of 1 to 3 clocks, chip-select gaps of 1 to 4, and conversion delays of 0 to 4 including the coincident-edge case. At these small values every edge distance can be measured to the exact clock. Short frames also leave room to land a stray tick and an input change in the middle of a period.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int NUM_CH = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_FRAME,
    ST_GAP,
    ST_STROBE
  } seqState_e;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic       latchShadow;
    logic       startFrame;
    logic [1:0] frameSel;   // 0..2 DAC channel, 3 ADC read
    logic       csDac;
    logic       csAdc;
    logic       ldac;
    logic       conv;
    logic       captureAdc;
  } seqCtl_t;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             frameDone,
  input  logic [CFG_W-1:0] csGap,
  input  logic [CFG_W-1:0] ldacGap,
  input  logic [CFG_W-1:0] convDelay,
  input  logic [CFG_W-1:0] pulseLen,
  output seqCtl_t          ctl,
  output logic             overrun
);
  localparam int CNT_W = CFG_W + 1;

  seqState_e  state;
  logic [1:0] frameIdx;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] gapLim;
  logic [CNT_W-1:0] strobeLast;

  assign gapLim     = (frameIdx == 2'd2) ? {1'b0, ldacGap} : {1'b0, csGap};
  assign strobeLast = {1'b0, convDelay} + {1'b0, pulseLen} - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      frameIdx <= '0;
      cnt      <= '0;
      overrun  <= 1'b0;
    end else begin
      if (tick && state != ST_IDLE) overrun <= 1'b1;
      unique case (state)
        ST_IDLE: if (tick) begin
          state    <= ST_LEAD;
          frameIdx <= 2'd0;
        end
        ST_LEAD: state <= ST_FRAME;
        ST_FRAME: if (frameDone) begin
          state <= ST_GAP;
          cnt   <= '0;
        end
        ST_GAP: begin
          if (cnt == gapLim - 1'b1) begin
            cnt <= '0;
            if (frameIdx == 2'd2)      state <= ST_STROBE;
            else if (frameIdx == 2'd3) state <= ST_IDLE;
            else begin
              frameIdx <= frameIdx + 1'b1;
              state    <= ST_LEAD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt == strobeLast) begin
            cnt      <= '0;
            frameIdx <= 2'd3;
            state    <= ST_LEAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl             = '0;
    ctl.latchShadow = (state == ST_IDLE) && tick;
    ctl.startFrame  = (state == ST_LEAD);
    ctl.frameSel    = frameIdx;
    ctl.csDac       = (state == ST_LEAD || state == ST_FRAME) && frameIdx != 2'd3;
    ctl.csAdc       = (state == ST_LEAD || state == ST_FRAME) && frameIdx == 2'd3;
    ctl.ldac        = (state == ST_STROBE) && (cnt < {1'b0, pulseLen});
    ctl.conv        = (state == ST_STROBE) && (cnt >= {1'b0, convDelay});
    ctl.captureAdc  = (state == ST_GAP) && frameIdx == 2'd3 && cnt == '0;
  end

  AST_DONE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> state == ST_FRAME); // R10
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun); // R8
  AST_BUSY_TICK_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (tick && state != ST_IDLE) |=> overrun); // R8
  AST_BUSY_TICK_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (tick && state == ST_FRAME) |=> !(state == ST_LEAD && frameIdx == 2'd0)); // R8
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FRAME_W  = 24,
  parameter int ADC_W    = 18,
  parameter int CFG_W    = 8,
  parameter int CMD_BASE = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqCtl_t                       ctl,
  input  logic [NUM_CH-1:0][DATA_W-1:0] chIn,
  input  logic [CFG_W-1:0]              sclkHalf,
  input  logic                          miso,
  output logic                          sclk,
  output logic                          mosi,
  output logic                          csDacN,
  output logic                          csAdcN,
  output logic                          ldacN,
  output logic                          convst,
  output logic [ADC_W-1:0]              adcData,
  output logic                          adcValid,
  output logic                          frameDone
);
  localparam int ADDR_W = FRAME_W - DATA_W;
  localparam int BIT_W  = $clog2(FRAME_W);

  logic [DATA_W-1:0]  shadow [NUM_CH];
  logic [DATA_W-1:0]  dataSel;
  logic [FRAME_W-1:0] frameWord, txShift, rxShift;
  logic [CFG_W-1:0]   halfCnt, halfLim;
  logic [BIT_W-1:0]   bitCnt;
  logic               busy, lastHalf;

  for (genvar g = 0; g < NUM_CH; g++) begin : gShadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                shadow[g] <= '0;
      else if (ctl.latchShadow) shadow[g] <= chIn[g];
    end
  end

  always_comb begin
    dataSel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ctl.frameSel == 2'(i)) dataSel = shadow[i];
    if (ctl.frameSel == 2'd3) frameWord = '0;
    else frameWord = {ADDR_W'(CMD_BASE) + ADDR_W'(ctl.frameSel), dataSel};
  end

  assign halfLim   = sclkHalf - 1'b1;
  assign lastHalf  = (halfCnt == halfLim);
  assign frameDone = busy && lastHalf && sclk && (bitCnt == BIT_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      halfCnt <= '0;
      bitCnt  <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else if (ctl.startFrame) begin
      busy    <= 1'b1;
      sclk    <= 1'b0;
      halfCnt <= '0;
      bitCnt  <= '0;
      txShift <= frameWord;
    end else if (busy) begin
      if (lastHalf) begin
        halfCnt <= '0;
        sclk    <= ~sclk;
        if (!sclk) begin
          mosi    <= txShift[FRAME_W-1];
          txShift <= txShift << 1;
        end else begin
          rxShift <= {rxShift[FRAME_W-2:0], miso};
          if (bitCnt == BIT_W'(FRAME_W - 1)) busy <= 1'b0;
          else bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csDacN   <= 1'b1;
      csAdcN   <= 1'b1;
      ldacN    <= 1'b1;
      convst   <= 1'b0;
      adcValid <= 1'b0;
      adcData  <= '0;
    end else begin
      csDacN   <= ~ctl.csDac;
      csAdcN   <= ~ctl.csAdc;
      ldacN    <= ~ctl.ldac;
      convst   <= ctl.conv;
      adcValid <= ctl.captureAdc;
      if (ctl.captureAdc) adcData <= rxShift[FRAME_W-1 -: ADC_W];
    end
  end

  AST_SINGLE_CS: assert property (@(posedge clk) disable iff (!rstN)
    !(!csDacN && !csAdcN)); // R4
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (csDacN && csAdcN) |-> !sclk); // R3
  AST_CS_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(csDacN && csAdcN)); // R4
  AST_STROBE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ldacN |-> (csDacN && csAdcN)); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    adcValid |=> !adcValid); // R7
  AST_MOSI_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(mosi) && !$past(ctl.startFrame)) |-> $rose(sclk)); // R3
endmodule

// File: rtl/dacAdcSequencer.sv
module dacAdcSequencer
  import seqPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FRAME_W  = 24,
  parameter int ADC_W    = 18,
  parameter int CFG_W    = 8,
  parameter int CMD_BASE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic [DATA_W-1:0] ch0Data,
  input  logic [DATA_W-1:0] ch1Data,
  input  logic [DATA_W-1:0] ch2Data,
  input  logic [CFG_W-1:0]  sclkHalf,
  input  logic [CFG_W-1:0]  csGap,
  input  logic [CFG_W-1:0]  ldacGap,
  input  logic [CFG_W-1:0]  convDelay,
  input  logic [CFG_W-1:0]  pulseLen,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              csDacN,
  output logic              csAdcN,
  output logic              ldacN,
  output logic              convst,
  output logic [ADC_W-1:0]  adcData,
  output logic              adcValid,
  output logic              overrun
);
  seqCtl_t ctl;
  logic    frameDone;

  seqCtrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (sampleTick),
    .frameDone (frameDone),
    .csGap     (csGap),
    .ldacGap   (ldacGap),
    .convDelay (convDelay),
    .pulseLen  (pulseLen),
    .ctl       (ctl),
    .overrun   (overrun)
  );

  seqDatapath #(
    .DATA_W   (DATA_W),
    .FRAME_W  (FRAME_W),
    .ADC_W    (ADC_W),
    .CFG_W    (CFG_W),
    .CMD_BASE (CMD_BASE)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .chIn      ({ch2Data, ch1Data, ch0Data}),
    .sclkHalf  (sclkHalf),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .csDacN    (csDacN),
    .csAdcN    (csAdcN),
    .ldacN     (ldacN),
    .convst    (convst),
    .adcData   (adcData),
    .adcValid  (adcValid),
    .frameDone (frameDone)
  );
endmodule

// File: tb/dacAdcSequencer_bench.sv
module dacAdcSequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 4;

  typedef struct packed {
    logic [15:0] d0, d1, d2;
    logic [23:0] pat;
    logic [7:0]  h, cg, lg, cd, pl;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{16'h1234, 16'hABCD, 16'h0F0F, 24'hA5C396, 8'd1, 8'd1, 8'd1, 8'd0, 8'd1},
    '{16'hFFFF, 16'h0000, 16'h8001, 24'hFFFFFF, 8'd2, 8'd3, 8'd2, 8'd4, 8'd2},
    '{16'h5555, 16'hAAAA, 16'h7FFE, 24'h123456, 8'd3, 8'd2, 8'd5, 8'd1, 8'd3},
    '{16'h0001, 16'h8000, 16'hC3C3, 24'h80003F, 8'd1, 8'd4, 8'd3, 8'd2, 8'd1}
  };

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, miso = 1'b0;
  logic [15:0] ch0 = '0, ch1 = '0, ch2 = '0;
  logic [7:0] sclkHalf = 8'd1, csGap = 8'd1, ldacGap = 8'd1, convDelay = 8'd0, pulseLen = 8'd1;
  logic sclk, mosi, csDacN, csAdcN, ldacN, convst, adcValid, overrun;
  logic [17:0] adcData;

  dacAdcSequencer u_dacAdcSequencer (
    .clk(clk), .rstN(rstN), .sampleTick(tick),
    .ch0Data(ch0), .ch1Data(ch1), .ch2Data(ch2),
    .sclkHalf(sclkHalf), .csGap(csGap), .ldacGap(ldacGap),
    .convDelay(convDelay), .pulseLen(pulseLen), .miso(miso),
    .sclk(sclk), .mosi(mosi), .csDacN(csDacN), .csAdcN(csAdcN),
    .ldacN(ldacN), .convst(convst), .adcData(adcData),
    .adcValid(adcValid), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int total = 0, fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus monitor and ADC model, sampled on the falling clock edge
  logic monClear = 1'b1;
  logic [23:0] curPat = '0;
  logic [23:0] dacFr [3];
  int dacLen [3];
  logic [23:0] dShift, aShift;
  int dBits, aBits, aRise, dacCount, adcCount, dLowStart, aLowStart, lastDacRise;
  int gapMin, gapMax, ldacFall, ldacLow, convRise, convHigh, strobeCount;
  int adcFallCyc, adcRiseCyc, validCount, validCyc, bothLow, idleSclk, mosiBad;
  logic [17:0] validData;
  logic pSclk = 0, pMosi = 0, pCsD = 1, pCsA = 1, pLdac = 1, pConv = 0;

  always @(negedge clk) begin
    if (monClear) begin
      dacCount = 0; adcCount = 0; dBits = 0; aBits = 0; aRise = 0;
      gapMin = 1 << 20; gapMax = -1; ldacFall = -1; ldacLow = -1; convRise = -1;
      convHigh = -1; strobeCount = 0; adcFallCyc = -1; adcRiseCyc = -1;
      validCount = 0; validCyc = -1; bothLow = 0; idleSclk = 0; mosiBad = 0;
      lastDacRise = -1; validData = '0; dShift = '0; aShift = '0;
    end else begin
      if (!csDacN && !csAdcN) bothLow++;
      if (csDacN && csAdcN && sclk) idleSclk++;
      if (mosi !== pMosi && !(sclk && !pSclk)) mosiBad++;
      if (sclk && !pSclk && !csAdcN) begin
        if (aRise < 24) miso <= curPat[23 - aRise];
        aRise++;
      end
      if (!sclk && pSclk) begin
        if (!csDacN) begin dShift = {dShift[22:0], mosi}; dBits++; end
        if (!csAdcN) begin aShift = {aShift[22:0], mosi}; aBits++; end
      end
      if (!csDacN && pCsD) begin
        if (dacCount > 0) begin
          if (cyc - lastDacRise < gapMin) gapMin = cyc - lastDacRise;
          if (cyc - lastDacRise > gapMax) gapMax = cyc - lastDacRise;
        end
        dLowStart = cyc; dBits = 0;
      end
      if (csDacN && !pCsD) begin
        if (dacCount < 3) begin
          dacFr[dacCount] = (dBits == 24) ? dShift : 24'hDEAD00;
          dacLen[dacCount] = cyc - dLowStart;
        end
        dacCount++; lastDacRise = cyc;
      end
      if (!csAdcN && pCsA) begin aLowStart = cyc; aBits = 0; aRise = 0; adcFallCyc = cyc; end
      if (csAdcN && !pCsA) begin adcCount++; adcRiseCyc = cyc; end
      if (!ldacN && pLdac) begin ldacFall = cyc; strobeCount++; end
      if (ldacN && !pLdac) ldacLow = cyc - ldacFall;
      if (convst && !pConv) convRise = cyc;
      if (!convst && pConv) convHigh = cyc - convRise;
      if (adcValid) begin validCount++; validCyc = cyc; validData = adcData; end
    end
    pSclk = sclk; pMosi = mosi; pCsD = csDacN; pCsA = csAdcN; pLdac = ldacN; pConv = convst;
  end

  task automatic pulseTick();
    @(posedge clk); #1 tick = 1'b1;
    @(posedge clk); #1 tick = 1'b0;
  endtask

  task automatic runSeq(input vec_t v, input bit midChange, input bit midTick);
    logic [23:0] expFr;
    @(posedge clk); #1;
    ch0 = v.d0; ch1 = v.d1; ch2 = v.d2; curPat = v.pat;
    sclkHalf = v.h; csGap = v.cg; ldacGap = v.lg; convDelay = v.cd; pulseLen = v.pl;
    monClear = 1'b1;
    @(posedge clk); #1 monClear = 1'b0;
    pulseTick();
    if (midChange) begin
      repeat (5) @(posedge clk); #1;
      ch0 = ~v.d0; ch1 = ~v.d1; ch2 = ~v.d2;          // R9
    end
    if (midTick) begin
      repeat (20) @(posedge clk);
      pulseTick();                                    // R8
    end
    for (int k = 0; k < 5000 && validCount == 0; k++) @(posedge clk);
    repeat (int'(v.cg) + 6) @(posedge clk);
    @(negedge clk); #1;
    chk(dacCount == 3, "R10", "dac frame count", dacCount, 3);
    for (int c = 0; c < 3; c++) begin
      expFr = {8'(8 + c), (c == 0) ? v.d0 : (c == 1) ? v.d1 : v.d2};
      chk(dacFr[c] == expFr, midChange ? "R9" : "R2", "dac frame word", dacFr[c], expFr);
      chk(dacLen[c] == 48 * int'(v.h) + 1, "R3", "dac cs low length", dacLen[c], 48 * int'(v.h) + 1);
    end
    chk(gapMin == int'(v.cg) && gapMax == int'(v.cg), "R4", "cs gap", gapMax, v.cg);
    chk(bothLow == 0, "R4", "both cs low", bothLow, 0);
    chk(idleSclk == 0 && mosiBad == 0, "R3", "sclk idle / mosi edge errors", idleSclk + mosiBad, 0);
    chk(ldacFall - lastDacRise == int'(v.lg), "R5", "cs to ldac", ldacFall - lastDacRise, v.lg);
    chk(ldacLow == int'(v.pl), "R5", "ldac width", ldacLow, v.pl);
    chk(convRise - ldacFall == int'(v.cd), "R6", "ldac to convst", convRise - ldacFall, v.cd);
    chk(convHigh == int'(v.pl), "R6", "convst width", convHigh, v.pl);
    chk(strobeCount == 1 && adcCount == 1 && validCount == 1, "R10", "strobe/read/valid counts",
        strobeCount * 100 + adcCount * 10 + validCount, 111);
    chk(adcFallCyc > ldacFall, "R10", "read after strobe", adcFallCyc, ldacFall);
    chk(aBits == 24 && aShift == 24'h0, "R7", "read frame bits and mosi", aShift, 0);
    chk(validData == v.pat[23:6], "R7", "adc word", validData, v.pat[23:6]);
    chk(validCyc == adcRiseCyc, "R7", "valid timing", validCyc, adcRiseCyc);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(csDacN && csAdcN && ldacN, "R1", "reset high pins", {csDacN, csAdcN, ldacN}, 3'b111);
    chk(!sclk && !convst && !mosi && !adcValid && !overrun, "R1", "reset low pins",
        {sclk, convst, mosi, adcValid, overrun}, 0);
    @(posedge clk); #1 rstN = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      runSeq(VECS[i], 1'b0, 1'b0);
      chk(overrun == 1'b0, "R8", "no overrun on clean period", overrun, 0);
    end

    runSeq(VECS[2], 1'b1, 1'b0);                   // R9 shadow capture
    runSeq(VECS[1], 1'b0, 1'b1);                   // R8 stray tick
    chk(overrun == 1'b1, "R8", "overrun set", overrun, 1);
    runSeq(VECS[0], 1'b0, 1'b0);
    chk(overrun == 1'b1, "R8", "overrun sticky", overrun, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; fails++;
    $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule